// File: doc/BRIEF.md
# Load Queue Ordering Checker

This block keeps the in-flight loads of an out-of-order core in a circular queue and finds memory-ordering violations. Each load gets a slot at the tail when it is allocated. At that moment it also keeps the store-queue tail that the caller supplies, or a marker saying that no older store exists. Once a load executes, its address is written into its slot. Until then the slot is flagged as unexecuted and can never match a store.

When a store resolves its address, the caller presents that address together with the load-queue index the store recorded at its own allocation, which is the first load younger than the store. The block scans from that index up to the current load tail. It looks for a load whose coarse address block (address shifted right by eight) equals the store's block. The first such load in age order is latched as the violator, and the store gets a fault flag. Only one violator is held at a time. While one is held, further scans are skipped. Reading the violator hands it over and clears it.

Loads leave from the head when commit presents a sequence number: every head load whose number is not larger goes, several in one cycle. A squash removes the youngest loads from the tail backward while their numbers exceed the squash number. A squash also drops a pending blocked-load condition that is younger than the squash point.

Top module: `ldq_order_check`

## Requirements
- R1: After a synchronous reset, head and tail are at slot 0, the count is 0, no violator is held, and no load is marked blocked.
- R2: The queue has LQ_CAP+1 slots and holds at most LQ_CAP loads. `lq_full` is high at LQ_CAP. An allocation while full is ignored and the tail does not move.
- R3: An allocation stores `alloc_sq_tail` with a valid flag, or an invalid flag when `alloc_sq_empty` is high. The query port returns this tag for `q_idx` one cycle later.
- R4: A store check covers slots from `st_lq_idx` up to, but not including, the load tail, wrapping at the last slot. Loads outside that range never match.
- R5: A load matches only when its address is valid and bits [ADDR_W-1:8] equal the store's. A load with no address update since allocation never matches.
- R6: `st_resp_valid` pulses one cycle after `st_valid`. When a match is found and no violator is held, the first matching slot in scan order becomes the violator, and `st_fault` rises in that same response cycle.
- R7: While a violator is held, a store check is skipped: no fault, and the violator index is unchanged.
- R8: `vio_rd` clears the held violator at the next edge. A new violator found by the same-cycle check is still latched.
- R9: A commit removes loads from the head, one after another in the same cycle, while the queue is not empty and the head's sequence number is at most `cm_seq`.
- R10: A squash removes loads from the tail backward while their sequence number exceeds `squash_seq`. A squash takes priority over a same-cycle allocation and commit.
- R11: `blk_set` marks a blocked load with `blk_seq`. A squash with `squash_seq` below the held blocked sequence clears the mark, unless `blk_set` sets it again in the same cycle.
- R12: `upd_valid` marks slot `upd_idx` as executed with `upd_addr`. A new allocation into a slot clears its executed mark, and this wins over a same-cycle update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tail | input | SQ_IDX_W | Store-queue tail at allocation |
| alloc_sq_empty | input | 1 | Store queue empty at allocation |
| lq_tail | output | IDX_W | Current tail slot |
| lq_count | output | CNT_W | Number of loads held |
| lq_full | output | 1 | Queue holds LQ_CAP loads |
| upd_valid | input | 1 | Load address update |
| upd_idx | input | IDX_W | Slot being updated |
| upd_addr | input | ADDR_W | Executed load address |
| st_valid | input | 1 | Store check request |
| st_addr | input | ADDR_W | Store address |
| st_lq_idx | input | IDX_W | First younger load slot recorded by the store |
| st_resp_valid | output | 1 | Store check response |
| st_fault | output | 1 | Store check found a violation |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash point sequence number |
| blk_set | input | 1 | Mark a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| load_blocked | output | 1 | Blocked-load mark held |
| vio_rd | input | 1 | Read and clear the violator |
| vio_valid | output | 1 | Violator held |
| vio_idx | output | IDX_W | Slot of the held violator |
| q_idx | input | IDX_W | Slot to query |
| q_tag_valid | output | 1 | Queried slot has an older store |
| q_tag | output | SQ_IDX_W | Queried slot's store-queue index |

## Verification
A wrong head or tail pointer shows at the very next edge in `lq_count`, `lq_tail` or `lq_full`. It also shifts the scan window, so a later store check reports a fault on the wrong slot or misses one. A stale executed flag or address shows as a spurious or missing `st_fault` on the first store whose block matches that slot. A violator register that fails to hold or clear shows in `vio_valid` and `vio_idx` one cycle after the store check or read.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  // Forward distance on a ring of n slots.
  function automatic int unsigned ring_fwd(input int unsigned base,
                                           input int unsigned delta,
                                           input int unsigned n);
    return (base + delta) % n;
  endfunction

  // Distance from a to b going forward on a ring of n slots.
  function automatic int unsigned ring_dist(input int unsigned from_pos,
                                            input int unsigned to_pos,
                                            input int unsigned n);
    return (to_pos + n - from_pos) % n;
  endfunction

  typedef enum logic [1:0] {
    PTR_HOLD   = 2'd0,
    PTR_SQUASH = 2'd1,
    PTR_ADV    = 2'd2
  } ptr_op_e;

endpackage

// File: rtl/ldq_range_scan.sv
module ldq_range_scan #(
  parameter int SLOTS     = 8,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic [ADDR_W-1:0] slot_addr [SLOTS],
  input  logic [SLOTS-1:0]  slot_ok,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [SLOTS-1:0] cand;

  // one block comparator per slot
  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign cand[i] = slot_ok[i] &&
      (slot_addr[i][ADDR_W-1:BLK_SHIFT] == probe_addr[ADDR_W-1:BLK_SHIFT]);
  end

  int unsigned span;
  assign span = ldq_pkg::ring_dist(int'(start_idx), int'(tail_idx), SLOTS);

  // first candidate in age order, starting at the store's younger-load slot
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int unsigned pos;
      pos = ldq_pkg::ring_fwd(int'(start_idx), k, SLOTS);
      if (!hit && (k < span) && cand[pos]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/ldq_retire_scan.sv
module ldq_retire_scan #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic [SEQ_W-1:0] slot_seq [SLOTS],
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] tail_idx,
  input  logic [CNT_W-1:0] count,
  input  logic [SEQ_W-1:0] cm_seq,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic [CNT_W-1:0] n_commit,
  output logic [CNT_W-1:0] n_squash
);
  // oldest-first run of loads at or below the commit point
  always_comb begin
    logic stop;
    int   n;
    stop = 1'b0;
    n    = 0;
    for (int k = 0; k < SLOTS; k++) begin
      int unsigned pos;
      pos = ldq_pkg::ring_fwd(int'(head_idx), k, SLOTS);
      if (!stop && (k < int'(count)) && (slot_seq[pos] <= cm_seq)) n++;
      else stop = 1'b1;
    end
    n_commit = CNT_W'(n);
  end

  // youngest-first run of loads above the squash point
  always_comb begin
    logic stop;
    int   n;
    stop = 1'b0;
    n    = 0;
    for (int k = 0; k < SLOTS; k++) begin
      int unsigned pos;
      pos = ldq_pkg::ring_fwd(int'(tail_idx), SLOTS - 1 - k, SLOTS);
      if (!stop && (k < int'(count)) && (slot_seq[pos] > squash_seq)) n++;
      else stop = 1'b1;
    end
    n_squash = CNT_W'(n);
  end
endmodule

// File: rtl/ldq_violation_reg.sv
module ldq_violation_reg #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_valid,
  input  logic             scan_hit,
  input  logic [IDX_W-1:0] scan_idx,
  input  logic             vio_rd,
  output logic             st_resp_valid,
  output logic             st_fault,
  output logic             vio_valid,
  output logic [IDX_W-1:0] vio_idx
);
  logic take;
  assign take = st_valid && !vio_valid && scan_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_resp_valid <= 1'b0;
      st_fault      <= 1'b0;
      vio_valid     <= 1'b0;
      vio_idx       <= '0;
    end else begin
      st_resp_valid <= st_valid;
      st_fault      <= take;
      if (vio_rd) vio_valid <= 1'b0;
      if (take) begin
        vio_valid <= 1'b1;
        vio_idx   <= scan_idx;
      end
    end
  end

  // R6: every check answers on the next cycle
  p_resp_next_r6: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> st_resp_valid);
  // R6: a reported fault always leaves a violator behind
  p_fault_holds_r6: assert property (@(posedge clk) disable iff (rst)
    st_fault |-> vio_valid);
  // R7: a held violator survives a check and suppresses its fault
  p_held_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (vio_valid && st_valid && !vio_rd) |=>
      (vio_valid && !st_fault && vio_idx == $past(vio_idx)));
  // R8: reading a held violator empties the register
  p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (vio_rd && vio_valid) |=> !vio_valid);
endmodule

// File: rtl/ldq_order_check.sv
module ldq_order_check #(
  parameter int LQ_CAP    = 7,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 16,
  parameter int SQ_IDX_W  = 4,
  parameter int BLK_SHIFT = 8,
  localparam int SLOTS    = LQ_CAP + 1,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_valid,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
  input  logic                alloc_sq_empty,
  output logic [IDX_W-1:0]    lq_tail,
  output logic [CNT_W-1:0]    lq_count,
  output logic                lq_full,
  input  logic                upd_valid,
  input  logic [IDX_W-1:0]    upd_idx,
  input  logic [ADDR_W-1:0]   upd_addr,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic [IDX_W-1:0]    st_lq_idx,
  output logic                st_resp_valid,
  output logic                st_fault,
  input  logic                cm_valid,
  input  logic [SEQ_W-1:0]    cm_seq,
  input  logic                squash_valid,
  input  logic [SEQ_W-1:0]    squash_seq,
  input  logic                blk_set,
  input  logic [SEQ_W-1:0]    blk_seq,
  output logic                load_blocked,
  input  logic                vio_rd,
  output logic                vio_valid,
  output logic [IDX_W-1:0]    vio_idx,
  input  logic [IDX_W-1:0]    q_idx,
  output logic                q_tag_valid,
  output logic [SQ_IDX_W-1:0] q_tag
);
  import ldq_pkg::*;

  logic [SEQ_W-1:0]    seq_mem  [SLOTS];
  logic [ADDR_W-1:0]   addr_mem [SLOTS];
  logic [SQ_IDX_W-1:0] tag_mem  [SLOTS];
  logic [SLOTS-1:0]    addr_ok;
  logic [SLOTS-1:0]    tag_ok;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             full;
  logic             alloc_ok;
  logic             upd_in_range, q_in_range;
  logic [CNT_W-1:0] n_commit, n_squash;
  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;
  logic             blk_q;
  logic [SEQ_W-1:0] blk_seq_q;
  ptr_op_e          ptr_op;

  assign full         = (count_q == CNT_W'(LQ_CAP));
  assign alloc_ok     = alloc_valid && !squash_valid && !full;
  assign upd_in_range = (int'(upd_idx) < SLOTS);
  assign q_in_range   = (int'(q_idx) < SLOTS);

  always_comb begin
    if (squash_valid)               ptr_op = PTR_SQUASH;
    else if (cm_valid || alloc_ok)  ptr_op = PTR_ADV;
    else                            ptr_op = PTR_HOLD;
  end

  // payload storage: plain write ports, no reset
  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      seq_mem[tail_q] <= alloc_seq;
      tag_mem[tail_q] <= alloc_sq_tail;
    end
    if (upd_valid && upd_in_range) addr_mem[upd_idx] <= upd_addr;
  end

  // per-slot flags; allocation overrides a same-slot update
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_ok <= '0;
      tag_ok  <= '0;
    end else begin
      if (upd_valid && upd_in_range) addr_ok[upd_idx] <= 1'b1;
      if (alloc_ok) begin
        addr_ok[tail_q] <= 1'b0;
        tag_ok[tail_q]  <= !alloc_sq_empty;
      end
    end
  end

  // ring pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      unique case (ptr_op)
        PTR_SQUASH: begin
          tail_q  <= IDX_W'(ring_fwd(int'(tail_q), SLOTS - int'(n_squash), SLOTS));
          count_q <= count_q - n_squash;
        end
        PTR_ADV: begin
          head_q  <= IDX_W'(ring_fwd(int'(head_q), cm_valid ? int'(n_commit) : 0, SLOTS));
          tail_q  <= IDX_W'(ring_fwd(int'(tail_q), alloc_ok ? 1 : 0, SLOTS));
          count_q <= count_q - (cm_valid ? n_commit : '0) + CNT_W'(alloc_ok);
        end
        default: ;
      endcase
    end
  end

  // query port and blocked-load mark
  always_ff @(posedge clk) begin
    if (rst) begin
      q_tag_valid <= 1'b0;
      q_tag       <= '0;
      blk_q       <= 1'b0;
      blk_seq_q   <= '0;
    end else begin
      q_tag_valid <= q_in_range && tag_ok[q_idx];
      q_tag       <= q_in_range ? tag_mem[q_idx] : '0;
      if (squash_valid && blk_q && (squash_seq < blk_seq_q)) blk_q <= 1'b0;
      if (blk_set) begin
        blk_q     <= 1'b1;
        blk_seq_q <= blk_seq;
      end
    end
  end

  ldq_retire_scan #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)
  ) u_retire (
    .slot_seq   (seq_mem),
    .head_idx   (head_q),
    .tail_idx   (tail_q),
    .count      (count_q),
    .cm_seq     (cm_seq),
    .squash_seq (squash_seq),
    .n_commit   (n_commit),
    .n_squash   (n_squash)
  );

  ldq_range_scan #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)
  ) u_scan (
    .slot_addr  (addr_mem),
    .slot_ok    (addr_ok),
    .start_idx  (st_lq_idx),
    .tail_idx   (tail_q),
    .probe_addr (st_addr),
    .hit        (scan_hit),
    .hit_idx    (scan_idx)
  );

  ldq_violation_reg #(.IDX_W(IDX_W)) u_vio (
    .clk           (clk),
    .rst           (rst),
    .st_valid      (st_valid),
    .scan_hit      (scan_hit),
    .scan_idx      (scan_idx),
    .vio_rd        (vio_rd),
    .st_resp_valid (st_resp_valid),
    .st_fault      (st_fault),
    .vio_valid     (vio_valid),
    .vio_idx       (vio_idx)
  );

  assign lq_tail      = tail_q;
  assign lq_count     = count_q;
  assign lq_full      = full;
  assign load_blocked = blk_q;

  // R2: occupancy never passes the usable capacity
  p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(LQ_CAP));
  // R2: allocation while full leaves the tail where it was
  p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (full && alloc_valid && !squash_valid) |=> (tail_q == $past(tail_q)));
  // R9: a commit with no allocation never grows the queue
  p_commit_shrink_r9: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && !alloc_valid && !squash_valid) |=> (count_q <= $past(count_q)));
  // R10: a squash never grows the queue and keeps the head
  p_squash_shrink_r10: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> (count_q <= $past(count_q) && head_q == $past(head_q)));
  // R11: an older squash drops the blocked mark
  p_block_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (squash_valid && blk_q && (squash_seq < blk_seq_q) && !blk_set) |=> !blk_q);
endmodule

// File: tb/ldq_order_check_tb_top.sv
module ldq_order_check_tb_top;
  localparam int CAP = 7;
  localparam int SL  = CAP + 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_valid, alloc_sq_empty;
  logic [15:0] alloc_seq;
  logic [3:0]  alloc_sq_tail;
  logic [2:0]  lq_tail;
  logic [3:0]  lq_count;
  logic        lq_full;
  logic        upd_valid;
  logic [2:0]  upd_idx;
  logic [31:0] upd_addr;
  logic        st_valid;
  logic [31:0] st_addr;
  logic [2:0]  st_lq_idx;
  logic        st_resp_valid, st_fault;
  logic        cm_valid;
  logic [15:0] cm_seq;
  logic        squash_valid;
  logic [15:0] squash_seq;
  logic        blk_set;
  logic [15:0] blk_seq;
  logic        load_blocked;
  logic        vio_rd, vio_valid;
  logic [2:0]  vio_idx;
  logic [2:0]  q_idx;
  logic        q_tag_valid;
  logic [3:0]  q_tag;

  always #5 clk = ~clk;

  ldq_order_check dut_i (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_sq_tail(alloc_sq_tail), .alloc_sq_empty(alloc_sq_empty),
    .lq_tail(lq_tail), .lq_count(lq_count), .lq_full(lq_full),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_addr(upd_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_lq_idx(st_lq_idx),
    .st_resp_valid(st_resp_valid), .st_fault(st_fault),
    .cm_valid(cm_valid), .cm_seq(cm_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .blk_set(blk_set), .blk_seq(blk_seq), .load_blocked(load_blocked),
    .vio_rd(vio_rd), .vio_valid(vio_valid), .vio_idx(vio_idx),
    .q_idx(q_idx), .q_tag_valid(q_tag_valid), .q_tag(q_tag)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int next_seq = 1;

  // reference model
  int          m_seq [SL];
  logic [31:0] m_addr[SL];
  bit          m_av  [SL];
  bit          m_tv  [SL];
  int          m_tag [SL];
  int          m_head, m_tail;
  bit          m_vv;
  int          m_vi;
  bit          m_blk;
  int          m_bseq;

  function automatic int mcount();
    return (m_tail - m_head + SL) % SL;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd_addr();
    return (32'($urandom % 4) << 8) | 32'($urandom % 256);
  endfunction

  task automatic idle();
    alloc_valid = 0; alloc_seq = 0; alloc_sq_tail = 0; alloc_sq_empty = 0;
    upd_valid = 0; upd_idx = 0; upd_addr = 0;
    st_valid = 0; st_addr = 0; st_lq_idx = 0;
    cm_valid = 0; cm_seq = 0; squash_valid = 0; squash_seq = 0;
    blk_set = 0; blk_seq = 0; vio_rd = 0; q_idx = 0;
  endtask

  task automatic model_reset();
    m_head = 0; m_tail = 0; m_vv = 0; m_vi = 0; m_blk = 0; m_bseq = 0;
    for (int i = 0; i < SL; i++) begin
      m_av[i] = 0; m_tv[i] = 0; m_seq[i] = 0; m_tag[i] = 0; m_addr[i] = 0;
    end
  endtask

  // one clock: predict from pre-edge model, clock, compare, then idle inputs
  task automatic step();
    bit e_qv; int e_qt; bit hit; int hidx; bit e_fault; bit e_resp;
    int cnt; bit was_full;
    e_qv = m_tv[q_idx]; e_qt = m_tag[q_idx];
    hit = 0; hidx = 0;
    if (st_valid) begin
      int span;
      span = (m_tail - int'(st_lq_idx) + SL) % SL;
      for (int k = 0; k < span; k++) begin
        int p;
        p = (int'(st_lq_idx) + k) % SL;
        if (!hit && m_av[p] && (m_addr[p] >> 8) == (st_addr >> 8)) begin
          hit = 1; hidx = p;
        end
      end
    end
    e_resp  = st_valid;
    e_fault = st_valid && !m_vv && hit;
    if (vio_rd) m_vv = 0;
    if (e_fault) begin m_vv = 1; m_vi = hidx; end
    if (squash_valid && m_blk && int'(squash_seq) < m_bseq) m_blk = 0;
    if (blk_set) begin m_blk = 1; m_bseq = int'(blk_seq); end
    cnt = mcount();
    was_full = (cnt == CAP);
    if (upd_valid) begin m_addr[upd_idx] = upd_addr; m_av[upd_idx] = 1; end
    if (squash_valid) begin
      while (mcount() > 0 && m_seq[(m_tail + SL - 1) % SL] > int'(squash_seq))
        m_tail = (m_tail + SL - 1) % SL;
    end else begin
      if (cm_valid)
        while (mcount() > 0 && m_seq[m_head] <= int'(cm_seq))
          m_head = (m_head + 1) % SL;
      if (alloc_valid && !was_full) begin
        m_seq[m_tail] = int'(alloc_seq);
        m_av[m_tail]  = 0;
        m_tv[m_tail]  = !alloc_sq_empty;
        m_tag[m_tail] = int'(alloc_sq_tail);
        m_tail = (m_tail + 1) % SL;
      end
    end
    @(posedge clk); #1;
    chk("R2 count", lq_count, mcount());
    chk("R2 tail", lq_tail, m_tail);
    chk("R2 full", lq_full, mcount() == CAP);
    chk("R6 response", st_resp_valid, e_resp);
    if (e_resp) chk("R6 fault", st_fault, e_fault);
    chk("R8 violator valid", vio_valid, m_vv);
    if (m_vv) chk("R6 violator index", vio_idx, m_vi);
    chk("R3 tag valid", q_tag_valid, e_qv);
    if (e_qv) chk("R3 tag", q_tag, e_qt);
    chk("R11 blocked", load_blocked, m_blk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", lq_count, 0);
    chk("R1 tail", lq_tail, 0);
    chk("R1 violator", vio_valid, 0);
    chk("R1 blocked", load_blocked, 0);
    chk("R1 full", lq_full, 0);
    rst = 0;

    // fill past capacity: slot i holds seq i+1
    for (int i = 0; i < SL; i++) begin
      alloc_valid = 1; alloc_seq = 16'(next_seq); next_seq++;
      alloc_sq_tail = 4'(i); alloc_sq_empty = (i == 1);
      step();
    end
    chk("R2 capacity", lq_count, CAP);
    chk("R2 full flag", lq_full, 1);
    q_idx = 1; step(); chk("R3 empty-store marker", q_tag_valid, 0);
    q_idx = 2; step(); chk("R3 store tail kept", q_tag, 2);

    st_valid = 1; st_addr = 32'h200; st_lq_idx = 0; step();
    chk("R5 unexecuted never matches", st_fault, 0);
    upd_valid = 1; upd_idx = 2; upd_addr = 32'h2A4; step();
    upd_valid = 1; upd_idx = 4; upd_addr = 32'h210; step();
    st_valid = 1; st_addr = 32'h2FF; st_lq_idx = 3; step();
    chk("R4 range starts at store index", st_fault, 1);
    chk("R4 violator slot", vio_idx, 4);
    st_valid = 1; st_addr = 32'h2FF; st_lq_idx = 0; step();
    chk("R7 skipped while held", st_fault, 0);
    chk("R7 index kept", vio_idx, 4);
    vio_rd = 1; step();
    chk("R8 read clears", vio_valid, 0);
    st_valid = 1; st_addr = 32'h2FF; st_lq_idx = 0; step();
    chk("R6 first match in order", vio_idx, 2);
    vio_rd = 1; step();

    blk_set = 1; blk_seq = 6; step();
    chk("R11 mark set", load_blocked, 1);
    cm_valid = 1; cm_seq = 3; step();
    chk("R9 multi commit", lq_count, 4);
    squash_valid = 1; squash_seq = 5; alloc_valid = 1; alloc_seq = 16'(next_seq); next_seq++;
    step();
    chk("R10 squash count", lq_count, 2);
    chk("R10 squash tail", lq_tail, 5);
    chk("R11 cleared by older squash", load_blocked, 0);

    upd_valid = 1; upd_idx = 5; upd_addr = 32'h300; step();
    alloc_valid = 1; alloc_seq = 16'(next_seq); next_seq++; step();
    st_valid = 1; st_addr = 32'h300; st_lq_idx = 3; step();
    chk("R12 realloc clears executed", st_fault, 0);
    upd_valid = 1; upd_idx = 5; upd_addr = 32'h3C0; step();
    st_valid = 1; st_addr = 32'h300; st_lq_idx = 3; step();
    chk("R12 update enables match", st_fault, 1);
    chk("R12 violator slot", vio_idx, 5);
    vio_rd = 1; step();

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      int cnt;
      cnt = mcount();
      if ($urandom % 100 < 45) begin
        alloc_valid = 1; alloc_seq = 16'(next_seq); next_seq++;
        alloc_sq_tail = 4'($urandom % 16); alloc_sq_empty = ($urandom % 4 == 0);
      end
      if (cnt > 0 && $urandom % 100 < 4) begin
        squash_valid = 1;
        squash_seq = 16'(m_seq[(m_head + int'($urandom % cnt)) % SL] - int'($urandom % 2));
      end
      if (cnt > 0 && $urandom % 100 < 20) begin
        cm_valid = 1; cm_seq = 16'(m_seq[(m_head + int'($urandom % cnt)) % SL]);
      end
      if (cnt > 0 && $urandom % 100 < 40) begin
        upd_valid = 1; upd_idx = 3'((m_head + int'($urandom % cnt)) % SL);
        upd_addr = rnd_addr();
      end
      if ($urandom % 100 < 15) begin
        st_valid = 1; st_addr = rnd_addr();
        st_lq_idx = 3'((m_head + int'($urandom % (cnt + 1))) % SL);
      end
      vio_rd = ($urandom % 100 < 15);
      if ($urandom % 100 < 5) begin
        blk_set = 1; blk_seq = 16'(next_seq - int'($urandom % 4));
      end
      q_idx = 3'($urandom % SL);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule